// File: doc/BRIEF.md
# Banked Data Address Generator

This block forms the 12-bit data-memory address for a small 8-bit microcontroller core and decides where an instruction's result is written. The decoder gives it, each cycle, the 8-bit file operand taken from the low byte of the opcode, an access-select bit, a destination bit, the 4-bit bank register value, a full 12-bit absolute operand for register-to-register moves, and a mode select. From these the block produces one effective address by one of three rules: it places the bank value above the operand, it maps the operand into a fixed access window, or it passes the absolute operand through unchanged.

In indirect mode the address comes from one of a small set of 12-bit pointer registers. The instruction can read through a pointer unchanged, post-increment it, post-decrement it, or read at the pointer plus the sign-extended working register without changing the pointer. Each pointer is also memory-mapped byte by byte, so the core can load its low byte or its high nibble directly. A direct load and an automatic update of the same pointer in one cycle resolve in favour of the direct load. The block reports each committed automatic update on a strobe, together with the pointer index and the new value.

Top module: `bank_addr_gen`

## Requirements
- R1: With `mode` = 2'b00 and `accessSel` = 1, `effAddr` equals `{bankSel, fileAddr}` (bank value in bits 11:8, operand in bits 7:0).
- R2: With `mode` = 2'b00 and `accessSel` = 0, an operand from 0x00 to 0x5F gives `effAddr` = 0x000 + operand, whatever `bankSel` holds.
- R3: With `mode` = 2'b00 and `accessSel` = 0, an operand from 0x60 to 0xFF gives `effAddr` = 0xF00 + operand, whatever `bankSel` holds.
- R4: With `mode` = 2'b01 (absolute move), `effAddr` equals `absAddr`, `bankSel` has no effect, and `writeFile` is 1.
- R5: In modes 2'b00 and indirect (`mode[1]` = 1), `writeFile` equals `destSel` (1 = file register, 0 = working register).
- R6: In indirect mode with `ptrOp` = 2'b00, `effAddr` is the selected pointer and the pointer keeps its value.
- R7: In indirect mode with `ptrOp` = 2'b01 and `valid` = 1, `effAddr` is the old pointer, `ptrUpdStb` is 1, `ptrUpdVal` is the pointer plus 1 modulo 4096, and the next access through that pointer sees the new value.
- R8: In indirect mode with `ptrOp` = 2'b10 and `valid` = 1, `effAddr` is the old pointer and the pointer becomes itself minus 1 modulo 4096 (0x000 becomes 0xFFF).
- R9: In indirect mode with `ptrOp` = 2'b11, `effAddr` is the pointer plus the sign-extended `wreg`, modulo 4096; the pointer is not changed and `ptrUpdStb` stays 0.
- R10: A direct load with `ptrWrHigh` = 0 sets pointer bits 7:0 to `ptrWrData`; with `ptrWrHigh` = 1 it sets bits 11:8 to `ptrWrData[3:0]`. The new value is used from the next cycle on.
- R11: When a direct load hits the same pointer as a post-increment or post-decrement in one cycle, the direct load is what the pointer keeps, and `ptrUpdStb` is 0.
- R12: After reset every pointer holds 0x000 and `ptrUpdStb` is 0.
- R13: With `valid` = 0 no pointer changes by automatic update and `ptrUpdStb` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | An instruction performs its data access this cycle |
| mode | input | 2 | 00 direct, 01 absolute, 1x indirect |
| fileAddr | input | 8 | File operand from the opcode low byte |
| accessSel | input | 1 | 1 = use bank register, 0 = access window |
| destSel | input | 1 | 1 = result to file register, 0 = to working register |
| bankSel | input | 4 | Bank register value |
| absAddr | input | 12 | Full address carried by an absolute move |
| ptrSel | input | 2 | Pointer used by an indirect access |
| ptrOp | input | 2 | 00 plain, 01 post-increment, 10 post-decrement, 11 offset |
| wreg | input | 8 | Working register, signed offset for ptrOp 11 |
| ptrWrEn | input | 1 | Direct load of one pointer byte |
| ptrWrSel | input | 2 | Pointer hit by the direct load |
| ptrWrHigh | input | 1 | 1 = load high nibble, 0 = load low byte |
| ptrWrData | input | 8 | Data of the direct load |
| effAddr | output | 12 | Effective data address |
| writeFile | output | 1 | 1 = write result to file register, 0 = to working register |
| ptrUpdStb | output | 1 | An automatic pointer update is committed this cycle |
| ptrUpdSel | output | 2 | Pointer being updated |
| ptrUpdVal | output | 12 | New pointer value |

## Verification
The bench targets the edge of the access window at operands 0x5F and 0x60, where a wrong comparison would send one of them into the wrong half of memory, and uses nonzero bank values so that a window which leaked the bank register shows up. It wraps pointers across 0xFFF and 0x000 in both directions and adds a negative offset, which a design with a truncated or zero-extended sum would turn into a wrong address. It sets a direct load against a post-increment of the same pointer, where a design that let the update win would leave the wrong value and still raise the strobe. Finally it walks a pointer from 0x100 by post-increment through all of bank 1 and counts 256 addresses, which catches an update that lags one cycle or skips a value.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [1:0] {
    PTR_PLAIN = 2'b00,
    PTR_INC   = 2'b01,
    PTR_DEC   = 2'b10,
    PTR_OFFS  = 2'b11
  } ptrOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic selAbs;   // absolute operand drives the address
    logic selInd;   // pointer path drives the address
    logic selBank;  // bank register joins the operand
    logic addOffs;  // pointer plus signed working register
    logic doInc;    // commit post-increment
    logic doDec;    // commit post-decrement
    logic wrFile;   // result goes to the file register
  } ctrlStb_t;

endpackage

// File: rtl/bag_ctrl.sv
module bag_ctrl
  import bag_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             valid,
  input  logic [1:0]       mode,
  input  logic             accessSel,
  input  logic             destSel,
  input  logic [1:0]       ptrOp,
  input  logic [SEL_W-1:0] ptrSel,
  input  logic             ptrWrEn,
  input  logic [SEL_W-1:0] ptrWrSel,
  output ctrlStb_t         stb
);

  ptrOp_e opDec;
  logic   isAbs;
  logic   isInd;
  logic   collide;

  always_comb begin
    opDec   = ptrOp_e'(ptrOp);
    isAbs   = (mode == 2'b01);
    isInd   = mode[1];
    // a direct byte load of the pointer in use overrides its auto-update
    collide = ptrWrEn && (ptrWrSel == ptrSel);

    stb.selAbs  = isAbs;
    stb.selInd  = isInd;
    stb.selBank = !isInd && !isAbs && accessSel;
    stb.addOffs = isInd && (opDec == PTR_OFFS);
    stb.doInc   = valid && isInd && (opDec == PTR_INC) && !collide;
    stb.doDec   = valid && isInd && (opDec == PTR_DEC) && !collide;
    stb.wrFile  = isAbs || destSel;
  end

endmodule

// File: rtl/bag_datapath.sv
module bag_datapath
  import bag_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              OPER_W    = 8,
  parameter int              NUM_PTRS  = 3,
  parameter int              SEL_W     = 2,
  parameter logic [OPER_W-1:0] ACC_SPLIT = 8'h60
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [OPER_W-1:0] fileAddr,
  input  logic [ADDR_W-OPER_W-1:0] bankSel,
  input  logic [ADDR_W-1:0] absAddr,
  input  logic [SEL_W-1:0]  ptrSel,
  input  logic [OPER_W-1:0] wreg,
  input  logic              ptrWrEn,
  input  logic [SEL_W-1:0]  ptrWrSel,
  input  logic              ptrWrHigh,
  input  logic [OPER_W-1:0] ptrWrData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              ptrUpd,
  output logic [ADDR_W-1:0] ptrUpdVal
);

  localparam int BANK_W = ADDR_W - OPER_W;

  logic [ADDR_W-1:0] ptrQ [NUM_PTRS];
  logic [ADDR_W-1:0] curPtr;
  logic [ADDR_W-1:0] offsSum;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] accessAddr;
  logic [ADDR_W-1:0] directAddr;

  // pointer storage, one register per pointer
  for (genvar g = 0; g < NUM_PTRS; g++) begin : gPtr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrQ[g] <= '0;
      end else if (ptrWrEn && (ptrWrSel == SEL_W'(g))) begin
        if (ptrWrHigh) ptrQ[g][ADDR_W-1:OPER_W] <= ptrWrData[BANK_W-1:0];
        else           ptrQ[g][OPER_W-1:0]      <= ptrWrData;
      end else if ((stb.doInc || stb.doDec) && (ptrSel == SEL_W'(g))) begin
        ptrQ[g] <= stepVal;
      end
    end
  end

  always_comb begin
    curPtr = '0;
    for (int i = 0; i < NUM_PTRS; i++) begin
      if (ptrSel == SEL_W'(i)) curPtr = ptrQ[i];
    end
  end

  always_comb begin
    offsSum = curPtr + {{BANK_W{wreg[OPER_W-1]}}, wreg};
    stepVal = stb.doDec ? (curPtr - ADDR_W'(1)) : (curPtr + ADDR_W'(1));

    if (fileAddr < ACC_SPLIT) accessAddr = {{BANK_W{1'b0}}, fileAddr};
    else                      accessAddr = {{BANK_W{1'b1}}, fileAddr};

    directAddr = stb.selBank ? {bankSel, fileAddr} : accessAddr;

    if (stb.selAbs)       effAddr = absAddr;
    else if (stb.selInd)  effAddr = stb.addOffs ? offsSum : curPtr;
    else                  effAddr = directAddr;
  end

  assign ptrUpd    = stb.doInc || stb.doDec;
  assign ptrUpdVal = stepVal;

endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
  import bag_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                OPER_W    = 8,
  parameter int                NUM_PTRS  = 3,
  parameter int                SEL_W     = 2,
  parameter logic [OPER_W-1:0] ACC_SPLIT = 8'h60
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     valid,
  input  logic [1:0]               mode,
  input  logic [OPER_W-1:0]        fileAddr,
  input  logic                     accessSel,
  input  logic                     destSel,
  input  logic [ADDR_W-OPER_W-1:0] bankSel,
  input  logic [ADDR_W-1:0]        absAddr,
  input  logic [SEL_W-1:0]         ptrSel,
  input  logic [1:0]               ptrOp,
  input  logic [OPER_W-1:0]        wreg,
  input  logic                     ptrWrEn,
  input  logic [SEL_W-1:0]         ptrWrSel,
  input  logic                     ptrWrHigh,
  input  logic [OPER_W-1:0]        ptrWrData,
  output logic [ADDR_W-1:0]        effAddr,
  output logic                     writeFile,
  output logic                     ptrUpdStb,
  output logic [SEL_W-1:0]         ptrUpdSel,
  output logic [ADDR_W-1:0]        ptrUpdVal
);

  ctrlStb_t stb;

  bag_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .valid     (valid),
    .mode      (mode),
    .accessSel (accessSel),
    .destSel   (destSel),
    .ptrOp     (ptrOp),
    .ptrSel    (ptrSel),
    .ptrWrEn   (ptrWrEn),
    .ptrWrSel  (ptrWrSel),
    .stb       (stb)
  );

  bag_datapath #(
    .ADDR_W    (ADDR_W),
    .OPER_W    (OPER_W),
    .NUM_PTRS  (NUM_PTRS),
    .SEL_W     (SEL_W),
    .ACC_SPLIT (ACC_SPLIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .fileAddr  (fileAddr),
    .bankSel   (bankSel),
    .absAddr   (absAddr),
    .ptrSel    (ptrSel),
    .wreg      (wreg),
    .ptrWrEn   (ptrWrEn),
    .ptrWrSel  (ptrWrSel),
    .ptrWrHigh (ptrWrHigh),
    .ptrWrData (ptrWrData),
    .effAddr   (effAddr),
    .ptrUpd    (ptrUpdStb),
    .ptrUpdVal (ptrUpdVal)
  );

  assign writeFile = stb.wrFile;
  assign ptrUpdSel = ptrSel;

endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int                ADDR_W    = 12,
  parameter int                OPER_W    = 8,
  parameter int                SEL_W     = 2,
  parameter logic [OPER_W-1:0] ACC_SPLIT = 8'h60
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     valid,
  input logic [1:0]               mode,
  input logic [OPER_W-1:0]        fileAddr,
  input logic                     accessSel,
  input logic                     destSel,
  input logic [ADDR_W-OPER_W-1:0] bankSel,
  input logic [ADDR_W-1:0]        absAddr,
  input logic [SEL_W-1:0]         ptrSel,
  input logic [1:0]               ptrOp,
  input logic                     ptrWrEn,
  input logic [SEL_W-1:0]         ptrWrSel,
  input logic [ADDR_W-1:0]        effAddr,
  input logic                     writeFile,
  input logic                     ptrUpdStb,
  input logic [SEL_W-1:0]         ptrUpdSel,
  input logic [ADDR_W-1:0]        ptrUpdVal
);

  localparam int BANK_W = ADDR_W - OPER_W;

  AST_BANKED_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && accessSel) |-> effAddr == {bankSel, fileAddr}); // R1

  AST_ACCESS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && !accessSel && fileAddr < ACC_SPLIT)
      |-> effAddr[ADDR_W-1:OPER_W] == {BANK_W{1'b0}}); // R2

  AST_ACCESS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00 && !accessSel && fileAddr >= ACC_SPLIT)
      |-> effAddr[ADDR_W-1:OPER_W] == {BANK_W{1'b1}}); // R3

  AST_ABS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |-> (effAddr == absAddr && writeFile)); // R4

  AST_DEST_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b01) |-> writeFile == destSel); // R5

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ptrUpdStb && ptrOp == 2'b01) |-> ptrUpdVal == effAddr + ADDR_W'(1)); // R7

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ptrUpdStb && ptrOp == 2'b10) |-> ptrUpdVal == effAddr - ADDR_W'(1)); // R8

  AST_UPD_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    ptrUpdStb |=> (!(mode[1] && ptrOp == 2'b00 && ptrSel == $past(ptrUpdSel))
                   || effAddr == $past(ptrUpdVal))); // R7

  AST_NO_STB_OFFS: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1] && ptrOp == 2'b11) |-> !ptrUpdStb); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ptrWrEn && ptrWrSel == ptrSel) |-> !ptrUpdStb); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> !ptrUpdStb); // R13

endmodule

bind bank_addr_gen bag_chk #(
  .ADDR_W    (ADDR_W),
  .OPER_W    (OPER_W),
  .SEL_W     (SEL_W),
  .ACC_SPLIT (ACC_SPLIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .valid     (valid),
  .mode      (mode),
  .fileAddr  (fileAddr),
  .accessSel (accessSel),
  .destSel   (destSel),
  .bankSel   (bankSel),
  .absAddr   (absAddr),
  .ptrSel    (ptrSel),
  .ptrOp     (ptrOp),
  .ptrWrEn   (ptrWrEn),
  .ptrWrSel  (ptrWrSel),
  .effAddr   (effAddr),
  .writeFile (writeFile),
  .ptrUpdStb (ptrUpdStb),
  .ptrUpdSel (ptrUpdSel),
  .ptrUpdVal (ptrUpdVal)
);

// File: tb/bank_addr_gen_tb.sv
`timescale 1ns/1ps
module bank_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        valid;
  logic [1:0]  mode;
  logic [7:0]  fileAddr;
  logic        accessSel;
  logic        destSel;
  logic [3:0]  bankSel;
  logic [11:0] absAddr;
  logic [1:0]  ptrSel;
  logic [1:0]  ptrOp;
  logic [7:0]  wreg;
  logic        ptrWrEn;
  logic [1:0]  ptrWrSel;
  logic        ptrWrHigh;
  logic [7:0]  ptrWrData;
  logic [11:0] effAddr;
  logic        writeFile;
  logic        ptrUpdStb;
  logic [1:0]  ptrUpdSel;
  logic [11:0] ptrUpdVal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bank_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .valid(valid), .mode(mode), .fileAddr(fileAddr),
    .accessSel(accessSel), .destSel(destSel), .bankSel(bankSel), .absAddr(absAddr),
    .ptrSel(ptrSel), .ptrOp(ptrOp), .wreg(wreg), .ptrWrEn(ptrWrEn),
    .ptrWrSel(ptrWrSel), .ptrWrHigh(ptrWrHigh), .ptrWrData(ptrWrData),
    .effAddr(effAddr), .writeFile(writeFile), .ptrUpdStb(ptrUpdStb),
    .ptrUpdSel(ptrUpdSel), .ptrUpdVal(ptrUpdVal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    valid = 0; mode = 2'b00; fileAddr = 8'h00; accessSel = 0; destSel = 0;
    bankSel = 4'h0; absAddr = 12'h000; ptrSel = 0; ptrOp = 2'b00; wreg = 8'h00;
    ptrWrEn = 0; ptrWrSel = 0; ptrWrHigh = 0; ptrWrData = 8'h00;
  endtask

  // new cycle: inputs change after the falling edge
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic loadByte(input logic [1:0] sel, input logic high, input logic [7:0] data);
    cyc();
    ptrWrEn = 1; ptrWrSel = sel; ptrWrHigh = high; ptrWrData = data;
  endtask

  task automatic setPtr(input logic [1:0] sel, input logic [11:0] val);
    loadByte(sel, 1'b0, val[7:0]);
    loadByte(sel, 1'b1, {4'h0, val[11:8]});
  endtask

  task automatic readPtr(input string tag, input logic [1:0] sel, input logic [11:0] exp);
    cyc();
    mode = 2'b10; ptrSel = sel; ptrOp = 2'b00; valid = 1;
    #1;
    chk(tag, effAddr, exp);
    chk({tag, " no strobe"}, ptrUpdStb, 1'b0);
  endtask

  task automatic direct(input string tag, input logic a, input logic [3:0] bank,
                        input logic [7:0] op, input logic [11:0] exp);
    cyc();
    valid = 1; mode = 2'b00; accessSel = a; bankSel = bank; fileAddr = op;
    #1;
    chk(tag, effAddr, exp);
  endtask

  task automatic t_reset();
    rstN = 0; idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk("R12 strobe after reset", ptrUpdStb, 1'b0);
    for (int p = 0; p < 3; p++) readPtr("R12 pointer cleared", 2'(p), 12'h000);
  endtask

  task automatic t_direct();
    direct("R1 bank 3 op 0x45", 1, 4'h3, 8'h45, 12'h345);
    direct("R1 bank F op 0x00", 1, 4'hF, 8'h00, 12'hF00);
    direct("R1 bank A op 0xFF", 1, 4'hA, 8'hFF, 12'hAFF);
    direct("R2 op 0x00 bank 7", 0, 4'h7, 8'h00, 12'h000);
    direct("R2 op 0x5F bank 9", 0, 4'h9, 8'h5F, 12'h05F);
    direct("R3 op 0x60 bank 2", 0, 4'h2, 8'h60, 12'hF60);
    direct("R3 op 0xFF bank 0", 0, 4'h0, 8'hFF, 12'hFFF);
  endtask

  task automatic t_absolute();
    cyc();
    valid = 1; mode = 2'b01; absAddr = 12'h7C3; bankSel = 4'h5; fileAddr = 8'h11;
    accessSel = 1; destSel = 0;
    #1;
    chk("R4 absolute address", effAddr, 12'h7C3);
    chk("R4 absolute writes file", writeFile, 1'b1);
  endtask

  task automatic t_dest();
    cyc();
    valid = 1; mode = 2'b00; destSel = 1;
    #1; chk("R5 direct dest file", writeFile, 1'b1);
    cyc();
    valid = 1; mode = 2'b00; destSel = 0;
    #1; chk("R5 direct dest W", writeFile, 1'b0);
    cyc();
    valid = 1; mode = 2'b11; destSel = 0;
    #1; chk("R5 indirect dest W", writeFile, 1'b0);
  endtask

  task automatic t_load();
    loadByte(2'd1, 1'b0, 8'h34);
    readPtr("R10 low byte load", 2'd1, 12'h034);
    loadByte(2'd1, 1'b1, 8'hA5);
    readPtr("R10 high nibble load", 2'd1, 12'h534);
    readPtr("R6 plain read keeps pointer", 2'd1, 12'h534);
    readPtr("R10 other pointer untouched", 2'd2, 12'h000);
  endtask

  task automatic t_incdec();
    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd1; ptrOp = 2'b01;
    #1;
    chk("R7 inc address is old value", effAddr, 12'h534);
    chk("R7 inc strobe", ptrUpdStb, 1'b1);
    chk("R7 inc new value", ptrUpdVal, 12'h535);
    chk("R7 inc strobe index", ptrUpdSel, 2'd1);
    readPtr("R7 inc visible next access", 2'd1, 12'h535);

    setPtr(2'd2, 12'hFFF);
    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd2; ptrOp = 2'b01;
    #1; chk("R7 inc wrap value", ptrUpdVal, 12'h000);
    readPtr("R7 inc wraps to 0x000", 2'd2, 12'h000);

    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd2; ptrOp = 2'b10;
    #1;
    chk("R8 dec address is old value", effAddr, 12'h000);
    chk("R8 dec strobe", ptrUpdStb, 1'b1);
    readPtr("R8 dec wraps to 0xFFF", 2'd2, 12'hFFF);
  endtask

  task automatic t_offset();
    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd1; ptrOp = 2'b11; wreg = 8'h80;
    #1;
    chk("R9 negative offset", effAddr, 12'h4B5);
    chk("R9 no strobe", ptrUpdStb, 1'b0);
    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd1; ptrOp = 2'b11; wreg = 8'h10;
    #1; chk("R9 positive offset", effAddr, 12'h545);
    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd2; ptrOp = 2'b11; wreg = 8'h05;
    #1; chk("R9 offset wraps", effAddr, 12'h004);
    readPtr("R9 pointer unchanged", 2'd1, 12'h535);
  endtask

  task automatic t_collide();
    cyc();
    valid = 1; mode = 2'b10; ptrSel = 2'd1; ptrOp = 2'b01;
    ptrWrEn = 1; ptrWrSel = 2'd1; ptrWrHigh = 0; ptrWrData = 8'h00;
    #1; chk("R11 strobe suppressed", ptrUpdStb, 1'b0);
    readPtr("R11 direct load wins", 2'd1, 12'h500);
  endtask

  task automatic t_invalid();
    cyc();
    valid = 0; mode = 2'b10; ptrSel = 2'd1; ptrOp = 2'b01;
    #1; chk("R13 no strobe when idle", ptrUpdStb, 1'b0);
    readPtr("R13 pointer unchanged when idle", 2'd1, 12'h500);
  endtask

  task automatic t_walk();
    int count = 0;
    bit done = 0;
    setPtr(2'd0, 12'h100);
    while (!done && count < 300) begin
      cyc();
      valid = 1; mode = 2'b10; ptrSel = 2'd0; ptrOp = 2'b01;
      #1;
      if (effAddr !== 12'h100 + 12'(count)) begin
        chk("R7 walk sequential address", effAddr, 12'h100 + 12'(count));
        done = 1;
      end
      count++;
      if (ptrUpdVal[11:8] != 4'h1) done = 1;
    end
    chk("R7 walk through bank 1 count", count, 256);
    readPtr("R7 walk ends at 0x200", 2'd0, 12'h200);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    t_reset();
    t_direct();
    t_absolute();
    t_dest();
    t_load();
    t_incdec();
    t_offset();
    t_collide();
    t_invalid();
    t_walk();
    cyc();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule